// File: doc/BRIEF.md
# Sparse-Window High Address Extender

This block maps a 32-bit CPU-side memory address onto a sparse bus window that can only reach 128 MB directly. A small extension register supplies the five top address bits that the window cannot carry. Addresses below 16 MB bypass the extension entirely. Higher addresses have their top five bits split off as the extension value, and the remaining offset is returned to the requester.

The extension value sits right-justified in the low bits of the register, not at its native bit position. The register is rewritten only when a request needs a different value. After such a write, the block refreshes its held copy by reading the register back. During that refresh cycle it takes no new requests.

There are two request ports. A lookup port returns the offset and the full bus address one cycle after acceptance. A direct-write port takes an extension address through the same translate-and-update path but produces no response. A read port always shows the held extension in byte-address form.

Top module: `hx_sparse_ext`

## Requirements
- R1: After reset the held extension is zero, `ext_rd_addr` reads 0, `rsp_valid` is low and `lk_ready` is high.
- R2: A request whose address is below 2^24 (bits 31:24 all zero) returns the address unchanged as its offset and leaves the extension and `lk_ready` unchanged.
- R3: A lookup at or above 2^24 returns as its offset the address with bits 31:27 cleared. The extension value is address bits 31:27.
- R4: The extension value is stored right-justified in a 5-bit register. `ext_rd_addr[31:27]` equals the extension value of the most recent updating request.
- R5: A request at or above 2^24 whose extension value equals the held value does not write the register, and `lk_ready` stays high in the following cycle.
- R6: A request at or above 2^24 with a different extension value writes the register on acceptance. `lk_ready` is then low for exactly one cycle, during which the held copy is refreshed from the register. The new value appears on `ext_rd_addr` in the cycle after that.
- R7: `ext_rd_addr` is the held extension shifted left by 27, and its bits 26:0 are always zero.
- R8: A direct write (`wr_valid`) passes through the same translate-and-update path as a lookup but gives no response. `wr_ready` is low whenever `lk_valid` is high or a refresh is in progress, so lookups take priority.
- R9: `rsp_bus_addr` is the request address for a bypass lookup. Otherwise it is the extension value concatenated with offset bits 26:0.
- R10: `rsp_valid` is high for exactly the cycle after each accepted lookup and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request present |
| lk_ready | output | 1 | Lookup can be accepted this cycle |
| lk_addr | input | 32 | Lookup physical address |
| wr_valid | input | 1 | Direct extension write present |
| wr_ready | output | 1 | Direct write can be accepted this cycle |
| wr_addr | input | 32 | Extension address for direct write |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_offset | output | 32 | In-window offset |
| rsp_bus_addr | output | 32 | Outbound bus address |
| ext_rd_addr | output | 32 | Held extension in byte-address form |

## Verification
The assertions assume the requester holds `lk_valid` and `wr_valid` at known levels after reset and accepts a response without back-pressure, since the response path has no ready signal. They also assume that a request offered while `lk_ready` is low is simply re-offered and not counted as accepted. The stimulus drives all inputs to zero throughout reset and changes them only at the falling edge. It keeps `lk_valid` asserted across refresh cycles in the back-to-back cases, so requests that are stalled and then accepted are covered. It mixes both ports, the 16 MB boundary and repeated extension values.

// File: rtl/hx_pkg.sv
package hx_pkg;
  localparam int unsigned HX_ADDR_W      = 32;
  localparam int unsigned HX_EXT_W       = 5;
  localparam int unsigned HX_BYPASS_LOG2 = 24;

  typedef enum logic [0:0] {
    HX_IDLE    = 1'b0,
    HX_REFRESH = 1'b1
  } hx_state_e;
endpackage

// File: rtl/hx_xlate.sv
module hx_xlate #(
  parameter int unsigned ADDR_W      = hx_pkg::HX_ADDR_W,
  parameter int unsigned EXT_W       = hx_pkg::HX_EXT_W,
  parameter int unsigned BYPASS_LOG2 = hx_pkg::HX_BYPASS_LOG2
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [EXT_W-1:0]  held,
  output logic              bypass,
  output logic [EXT_W-1:0]  ext,
  output logic [ADDR_W-1:0] offset,
  output logic [ADDR_W-1:0] bus,
  output logic              need_upd
);
  localparam int unsigned EXT_LSB = ADDR_W - EXT_W;

  function automatic logic below_threshold(input logic [ADDR_W-1:0] a);
    return ~|a[ADDR_W-1:BYPASS_LOG2];
  endfunction

  function automatic logic [EXT_W-1:0] ext_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:EXT_LSB];
  endfunction

  function automatic logic [ADDR_W-1:0] strip_ext(input logic [ADDR_W-1:0] a);
    return {{EXT_W{1'b0}}, a[EXT_LSB-1:0]};
  endfunction

  always_comb begin
    bypass   = below_threshold(addr);
    ext      = ext_of(addr);
    offset   = bypass ? addr : strip_ext(addr);
    bus      = bypass ? addr : {ext, offset[EXT_LSB-1:0]};
    need_upd = !bypass && (ext != held);
  end
endmodule

// File: rtl/hx_ext_reg.sv
module hx_ext_reg #(
  parameter int unsigned EXT_W = hx_pkg::HX_EXT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [EXT_W-1:0] wr_data,
  output logic [EXT_W-1:0] rd_value
);
  logic [EXT_W-1:0] value_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     value_q <= '0;
    else if (wr_en) value_q <= wr_data;
  end

  assign rd_value = value_q;
endmodule

// File: rtl/hx_ctrl.sv
module hx_ctrl #(
  parameter int unsigned ADDR_W = hx_pkg::HX_ADDR_W,
  parameter int unsigned EXT_W  = hx_pkg::HX_EXT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic              wr_valid,
  output logic              lk_ready,
  output logic              wr_ready,
  input  logic              x_need_upd,
  input  logic [EXT_W-1:0]  x_ext,
  input  logic [ADDR_W-1:0] x_offset,
  input  logic [ADDR_W-1:0] x_bus,
  input  logic [EXT_W-1:0]  reg_value,
  output logic [EXT_W-1:0]  held_q,
  output logic              reg_wr_en,
  output logic [EXT_W-1:0]  reg_wr_data,
  output logic              rsp_valid,
  output logic [ADDR_W-1:0] rsp_offset,
  output logic [ADDR_W-1:0] rsp_bus_addr,
  output logic              acc_lookup,
  output logic              upd_fire,
  output logic              refresh_fire
);
  import hx_pkg::*;

  hx_state_e state_q;
  logic      acc_write;
  logic      acc_any;

  assign lk_ready     = (state_q == HX_IDLE);
  assign wr_ready     = (state_q == HX_IDLE) && !lk_valid;
  assign acc_lookup   = lk_valid && lk_ready;
  assign acc_write    = wr_valid && wr_ready;
  assign acc_any      = acc_lookup || acc_write;
  assign upd_fire     = acc_any && x_need_upd;
  assign refresh_fire = (state_q == HX_REFRESH);
  assign reg_wr_en    = upd_fire;
  assign reg_wr_data  = x_ext;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q      <= HX_IDLE;
      held_q       <= '0;
      rsp_valid    <= 1'b0;
      rsp_offset   <= '0;
      rsp_bus_addr <= '0;
    end else begin
      rsp_valid <= acc_lookup;
      if (acc_lookup) begin
        rsp_offset   <= x_offset;
        rsp_bus_addr <= x_bus;
      end
      case (state_q)
        HX_IDLE:    if (upd_fire) state_q <= HX_REFRESH;
        HX_REFRESH: begin
          held_q  <= reg_value;
          state_q <= HX_IDLE;
        end
        default:    state_q <= HX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hx_sparse_ext.sv
module hx_sparse_ext #(
  parameter int unsigned ADDR_W      = hx_pkg::HX_ADDR_W,
  parameter int unsigned EXT_W       = hx_pkg::HX_EXT_W,
  parameter int unsigned BYPASS_LOG2 = hx_pkg::HX_BYPASS_LOG2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  output logic              lk_ready,
  input  logic [ADDR_W-1:0] lk_addr,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic              rsp_valid,
  output logic [ADDR_W-1:0] rsp_offset,
  output logic [ADDR_W-1:0] rsp_bus_addr,
  output logic [ADDR_W-1:0] ext_rd_addr
);
  localparam int unsigned EXT_LSB = ADDR_W - EXT_W;

  function automatic logic [ADDR_W-1:0] byte_form(input logic [EXT_W-1:0] e);
    return {e, {EXT_LSB{1'b0}}};
  endfunction

  logic [ADDR_W-1:0] sel_addr;
  logic              x_bypass;
  logic [EXT_W-1:0]  x_ext;
  logic [ADDR_W-1:0] x_offset;
  logic [ADDR_W-1:0] x_bus;
  logic              x_need_upd;
  logic [EXT_W-1:0]  held_q;
  logic [EXT_W-1:0]  reg_value;
  logic              reg_wr_en;
  logic [EXT_W-1:0]  reg_wr_data;
  logic              acc_lookup;
  logic              upd_fire;
  logic              refresh_fire;

  assign sel_addr = lk_valid ? lk_addr : wr_addr;

  hx_xlate #(.ADDR_W(ADDR_W), .EXT_W(EXT_W), .BYPASS_LOG2(BYPASS_LOG2)) xlate_i (
    .addr     (sel_addr),
    .held     (held_q),
    .bypass   (x_bypass),
    .ext      (x_ext),
    .offset   (x_offset),
    .bus      (x_bus),
    .need_upd (x_need_upd)
  );

  hx_ext_reg #(.EXT_W(EXT_W)) ext_reg_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (reg_wr_en),
    .wr_data  (reg_wr_data),
    .rd_value (reg_value)
  );

  hx_ctrl #(.ADDR_W(ADDR_W), .EXT_W(EXT_W)) ctrl_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .lk_valid     (lk_valid),
    .wr_valid     (wr_valid),
    .lk_ready     (lk_ready),
    .wr_ready     (wr_ready),
    .x_need_upd   (x_need_upd),
    .x_ext        (x_ext),
    .x_offset     (x_offset),
    .x_bus        (x_bus),
    .reg_value    (reg_value),
    .held_q       (held_q),
    .reg_wr_en    (reg_wr_en),
    .reg_wr_data  (reg_wr_data),
    .rsp_valid    (rsp_valid),
    .rsp_offset   (rsp_offset),
    .rsp_bus_addr (rsp_bus_addr),
    .acc_lookup   (acc_lookup),
    .upd_fire     (upd_fire),
    .refresh_fire (refresh_fire)
  );

  assign ext_rd_addr = byte_form(held_q);
endmodule

// File: rtl/hx_sparse_ext_chk.sv
module hx_sparse_ext_chk #(
  parameter int unsigned ADDR_W      = hx_pkg::HX_ADDR_W,
  parameter int unsigned EXT_W       = hx_pkg::HX_EXT_W,
  parameter int unsigned BYPASS_LOG2 = hx_pkg::HX_BYPASS_LOG2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lk_valid,
  input logic              lk_ready,
  input logic [ADDR_W-1:0] lk_addr,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] rsp_offset,
  input logic [ADDR_W-1:0] rsp_bus_addr,
  input logic [ADDR_W-1:0] ext_rd_addr,
  input logic              acc_lookup,
  input logic              upd_fire,
  input logic              refresh_fire,
  input logic [EXT_W-1:0]  reg_value
);
  localparam int unsigned EXT_LSB = ADDR_W - EXT_W;

  AST_BYPASS_KEEPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_ready && ~|lk_addr[ADDR_W-1:BYPASS_LOG2]) |=> lk_ready); // R2
  AST_OFFSET_TOP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ~|rsp_offset[ADDR_W-1:EXT_LSB]); // R3
  AST_NO_WRITE_SAME: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_lookup && !upd_fire) |=> ($stable(ext_rd_addr) && lk_ready)); // R5
  AST_REFRESH_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    upd_fire |=> (refresh_fire && !lk_ready && !wr_ready)); // R6
  AST_REFRESH_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_fire |=> !refresh_fire); // R6
  AST_HELD_FROM_REG: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_fire |=> (ext_rd_addr[ADDR_W-1:EXT_LSB] == $past(reg_value))); // R4
  AST_READ_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ~|ext_rd_addr[EXT_LSB-1:0]); // R7
  AST_LOOKUP_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid || wr_valid && !lk_ready) |-> !wr_ready); // R8
  AST_BUS_LOW_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_bus_addr[EXT_LSB-1:0] == rsp_offset[EXT_LSB-1:0])); // R9
  AST_RSP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    acc_lookup |=> rsp_valid); // R10
  AST_RSP_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_lookup |=> !rsp_valid); // R10
endmodule

bind hx_sparse_ext hx_sparse_ext_chk #(
  .ADDR_W(ADDR_W), .EXT_W(EXT_W), .BYPASS_LOG2(BYPASS_LOG2)
) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .lk_valid     (lk_valid),
  .lk_ready     (lk_ready),
  .lk_addr      (lk_addr),
  .wr_valid     (wr_valid),
  .wr_ready     (wr_ready),
  .rsp_valid    (rsp_valid),
  .rsp_offset   (rsp_offset),
  .rsp_bus_addr (rsp_bus_addr),
  .ext_rd_addr  (ext_rd_addr),
  .acc_lookup   (acc_lookup),
  .upd_fire     (upd_fire),
  .refresh_fire (refresh_fire),
  .reg_value    (reg_value)
);

// File: tb/hx_sparse_ext_tb_top.sv
module hx_sparse_ext_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0;
  logic        lk_ready;
  logic [31:0] lk_addr = '0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [31:0] wr_addr = '0;
  logic        rsp_valid;
  logic [31:0] rsp_offset;
  logic [31:0] rsp_bus_addr;
  logic [31:0] ext_rd_addr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Behavioural reference state (describes the current cycle).
  int          m_held = 0;
  int          m_reg  = 0;
  bit          m_busy = 1'b0;
  bit          m_rsp_v = 1'b0;
  logic [31:0] m_rsp_off = '0;
  logic [31:0] m_rsp_bus = '0;
  bit          m_rsp_byp = 1'b0;

  always #2.5 clk = ~clk;

  hx_sparse_ext dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .lk_valid     (lk_valid),
    .lk_ready     (lk_ready),
    .lk_addr      (lk_addr),
    .wr_valid     (wr_valid),
    .wr_ready     (wr_ready),
    .wr_addr      (wr_addr),
    .rsp_valid    (rsp_valid),
    .rsp_offset   (rsp_offset),
    .rsp_bus_addr (rsp_bus_addr),
    .ext_rd_addr  (ext_rd_addr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] byte_of(input int e);
    logic [31:0] v;
    v = 32'(e) * 32'd134217728;
    return v;
  endfunction

  // One clock cycle: drive at the falling edge, compare, then advance the model.
  task automatic step(input bit lv, input logic [31:0] la, input bit wv, input logic [31:0] wa);
    bit          acc_l, acc_w, n_busy;
    int          n_held, n_reg, e;
    logic [31:0] a;
    @(negedge clk);
    lk_valid = lv; lk_addr = la; wr_valid = wv; wr_addr = wa;
    #1;
    chk("R6 lk_ready", {31'd0, lk_ready}, {31'd0, !m_busy});
    chk("R8 wr_ready", {31'd0, wr_ready}, {31'd0, !m_busy && !lv});
    chk("R10 rsp_valid", {31'd0, rsp_valid}, {31'd0, m_rsp_v});
    if (m_rsp_v) begin
      chk(m_rsp_byp ? "R2 offset" : "R3 offset", rsp_offset, m_rsp_off);
      chk("R9 bus address", rsp_bus_addr, m_rsp_bus);
    end
    chk("R7 ext read", ext_rd_addr, byte_of(m_held));
    acc_l  = lv && !m_busy;
    acc_w  = wv && !m_busy && !lv;
    n_held = m_held; n_reg = m_reg; n_busy = 1'b0;
    if (m_busy) n_held = m_reg;
    m_rsp_v = acc_l;
    if (acc_l || acc_w) begin
      a = acc_l ? la : wa;
      e = int'(a / 32'd134217728);
      if (a < 32'd16777216) begin
        if (acc_l) begin m_rsp_off = a; m_rsp_bus = a; m_rsp_byp = 1'b1; end
      end else begin
        if (acc_l) begin
          m_rsp_off = a - byte_of(e);
          m_rsp_bus = byte_of(e) + m_rsp_off;
          m_rsp_byp = 1'b0;
        end
        if (e != m_held) begin n_reg = e; n_busy = 1'b1; end
      end
    end
    m_held = n_held; m_reg = n_reg; m_busy = n_busy;
  endtask

  // Look at outputs just after the coming rising edge (inputs unchanged).
  task automatic peek();
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state
    chk("R1 lk_ready", {31'd0, lk_ready}, 32'd1);
    chk("R1 ext read", ext_rd_addr, 32'd0);
    chk("R1 rsp_valid", {31'd0, rsp_valid}, 32'd0);

    // R2: bypass lookups, including the address just below 16 MB
    step(1, 32'h0012_3456, 0, '0);
    step(1, 32'h00FF_FFFF, 0, '0);
    peek();
    chk("R2 ready kept", {31'd0, lk_ready}, 32'd1);
    chk("R2 ext unchanged", ext_rd_addr, 32'd0);
    step(0, '0, 0, '0);

    // R5: exactly 16 MB has extension 0 == held, no write
    step(1, 32'h0100_0000, 0, '0);
    peek();
    chk("R5 no stall", {31'd0, lk_ready}, 32'd1);
    step(0, '0, 0, '0);

    // R3 and R6: high address with new extension 9
    step(1, 32'h4800_1234, 0, '0);
    step(0, '0, 0, '0);
    step(0, '0, 0, '0);
    peek();
    chk("R4 ext bits", {27'd0, ext_rd_addr[31:27]}, 32'd9);
    chk("R3 offset", rsp_offset, 32'h0000_1234);

    // back-to-back lookups held through a refresh stall
    step(1, 32'hF000_0010, 0, '0);
    step(1, 32'hF7FF_FFF0, 0, '0);
    step(1, 32'hF7FF_FFF0, 0, '0);
    step(1, 32'h0800_0000, 0, '0);
    step(1, 32'h0800_0000, 0, '0);
    step(0, '0, 0, '0);

    // R8: direct write alone, then colliding with a lookup
    step(0, '0, 1, 32'hF800_0000);
    step(0, '0, 0, '0);
    step(0, '0, 0, '0);
    peek();
    chk("R8 direct write ext", ext_rd_addr, 32'hF800_0000);
    chk("R8 no response", {31'd0, rsp_valid}, 32'd0);
    step(1, 32'h0000_0040, 1, 32'h1000_0000);
    step(0, '0, 0, '0);
    peek();
    chk("R8 write blocked", ext_rd_addr, 32'hF800_0000);
    step(0, '0, 1, 32'h0000_1000);
    step(0, '0, 0, '0);
    peek();
    chk("R2 low direct write", ext_rd_addr, 32'hF800_0000);

    // mixed pseudo-random traffic
    lfsr = 32'h1D87_2B41;
    for (int i = 0; i < 400; i++) begin
      lfsr = lfsr ^ (lfsr << 13);
      lfsr = lfsr ^ (lfsr >> 17);
      lfsr = lfsr ^ (lfsr << 5);
      step(lfsr[0], (lfsr[3] ? {lfsr[31:29], 29'h0} : 32'h0) | {8'h0, lfsr[23:0]} | {lfsr[4], 31'h0},
           lfsr[1], {lfsr[27:23], 3'b0, lfsr[22:0], 1'b0});
    end
    step(0, '0, 0, '0);
    step(0, '0, 0, '0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule